// File: doc/BRIEF.md
# Pipelined Decision-Tree Flow Classifier

This block assigns an application class to each network flow by walking a binary decision tree that is held in on-chip node tables. Each flow comes in as a vector of flow-level features. Each feature has already been quantised into a bin index. At every internal node the walk picks one feature, compares its bin against the node's split bin, and moves to one of two children. It stops at the first node marked as a leaf, and that node supplies the class label.

The tree is laid out one level per pipeline stage. Each level has its own node table, read with the node index that the previous stage handed on. A new flow can therefore enter on every clock cycle. Flows that hit a leaf early carry their label unchanged through the remaining stages, so every result has the same latency and results leave in arrival order. Input and output use valid/ready handshakes, and a stalled output freezes the whole pipeline.

A configuration port writes one node entry per cycle into a chosen level. The tree can be replaced at run time without changing the hardware. Writes take effect only while no flow is in flight.

Top module: `dtc_classifier`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Every node table entry is cleared, so a flow classified before any programming yields class 0.
- R2: The feature bus packs feature i at bits [i*BIN_W +: BIN_W]. At a non-leaf node, the walk reads the feature named by the node's feature select. It goes to the left child index when that bin is less than or equal to the split bin, and to the right child index otherwise.
- R3: The result class is the class field of the first leaf node on the walk. A node at the deepest level (level DEPTH-1) always ends the walk with its class field, whatever its leaf flag says.
- R4: With out_ready held high, a flow accepted on a clock edge appears on out_valid/out_class on the DEPTH-th clock edge after it.
- R5: Flows offered on consecutive cycles are all accepted back to back while out_ready is high. Their results come out in the order the flows were accepted, one per cycle.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_class keeps its value on the next cycle. No result is lost or duplicated under backpressure.
- R7: While cfg_we is 1, in_ready is 0. A node write issued while any flow is in flight is discarded and does not change later results.
- R8: A node write issued while the pipeline is empty stores the entry at table cfg_level, index cfg_node. The tree root is entry 0 of level 0. A rewritten entry changes the class of later flows that reach it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Feature vector offered |
| in_ready | output | 1 | Block accepts the offered vector this cycle |
| in_feat | input | N_FEAT*BIN_W | Packed feature bins, feature i at [i*BIN_W +: BIN_W] |
| out_valid | output | 1 | Class result available |
| out_ready | input | 1 | Downstream takes the result |
| out_class | output | CLASS_W | Class label of the flow |
| cfg_we | input | 1 | Node write request |
| cfg_level | input | max(1,clog2(DEPTH)) | Tree level of the written node |
| cfg_node | input | ADDR_W | Node index within that level |
| cfg_fsel | input | max(1,clog2(N_FEAT)) | Feature select of the node |
| cfg_split | input | BIN_W | Split bin of the node |
| cfg_left | input | ADDR_W | Child index at the next level when bin <= split |
| cfg_right | input | ADDR_W | Child index at the next level when bin > split |
| cfg_leaf | input | 1 | Node ends the walk |
| cfg_class | input | CLASS_W | Class given when the walk ends here |

## Verification
A wrong child index, a reversed comparison or a wrong feature select sends the walk into another branch. That shows as a wrong out_class exactly DEPTH edges after the flow is accepted, and it only appears for flows whose bins sit on the affected side of a split. For that reason the vectors straddle each split bin, including equality. A leaf label that gets lost on its way through later stages changes the class of early-leaf flows only. A stall that is not honoured shows on the very next cycle as a changed label or a missing or extra result. A write that slips in while flows are in flight shows on the next flow that visits the rewritten node.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  // What one tree level does with the flow in front of it.
  typedef enum logic [1:0] {
    STEP_PASS  = 2'd0,  // walk already finished upstream
    STEP_LEAF  = 2'd1,  // walk finishes here
    STEP_LEFT  = 2'd2,  // bin <= split
    STEP_RIGHT = 2'd3   // bin >  split
  } step_e;

  // Width of an index for n items, never below one bit.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Decision made by one level for one flow.
  function automatic step_e pick_step(input logic done, input logic leaf,
                                      input logic deepest,
                                      input int unsigned bin,
                                      input int unsigned split);
    if (done)            return STEP_PASS;
    if (leaf || deepest) return STEP_LEAF;
    if (bin <= split)    return STEP_LEFT;
    return STEP_RIGHT;
  endfunction

endpackage

// File: rtl/dtc_node_mem.sv
module dtc_node_mem #(
  parameter int ADDR_W  = 4,
  parameter int FSEL_W  = 2,
  parameter int BIN_W   = 4,
  parameter int CLASS_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FSEL_W-1:0]  wr_fsel,
  input  logic [BIN_W-1:0]   wr_split,
  input  logic [ADDR_W-1:0]  wr_left,
  input  logic [ADDR_W-1:0]  wr_right,
  input  logic               wr_leaf,
  input  logic [CLASS_W-1:0] wr_class,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [FSEL_W-1:0]  rd_fsel,
  output logic [BIN_W-1:0]   rd_split,
  output logic [ADDR_W-1:0]  rd_left,
  output logic [ADDR_W-1:0]  rd_right,
  output logic               rd_leaf,
  output logic [CLASS_W-1:0] rd_class
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [FSEL_W-1:0]  t_fsel  [ENTRIES];
  logic [BIN_W-1:0]   t_split [ENTRIES];
  logic [ADDR_W-1:0]  t_left  [ENTRIES];
  logic [ADDR_W-1:0]  t_right [ENTRIES];
  logic               t_leaf  [ENTRIES];
  logic [CLASS_W-1:0] t_class [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        t_fsel[i]  <= '0;
        t_split[i] <= '0;
        t_left[i]  <= '0;
        t_right[i] <= '0;
        t_leaf[i]  <= 1'b0;
        t_class[i] <= '0;
      end
    end else if (wr_en) begin
      t_fsel[wr_addr]  <= wr_fsel;
      t_split[wr_addr] <= wr_split;
      t_left[wr_addr]  <= wr_left;
      t_right[wr_addr] <= wr_right;
      t_leaf[wr_addr]  <= wr_leaf;
      t_class[wr_addr] <= wr_class;
    end
  end

  // Asynchronous read: the stage decides within the same cycle.
  assign rd_fsel  = t_fsel[rd_addr];
  assign rd_split = t_split[rd_addr];
  assign rd_left  = t_left[rd_addr];
  assign rd_right = t_right[rd_addr];
  assign rd_leaf  = t_leaf[rd_addr];
  assign rd_class = t_class[rd_addr];

  // R7: the table never changes under a flow in flight.
  a_r7_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy);

endmodule

// File: rtl/dtc_stage.sv
module dtc_stage
  import dtc_pkg::*;
#(
  parameter int N_FEAT  = 4,
  parameter int BIN_W   = 4,
  parameter int FSEL_W  = 2,
  parameter int ADDR_W  = 4,
  parameter int CLASS_W = 3,
  parameter bit DEEPEST = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     in_vld,
  input  logic [N_FEAT*BIN_W-1:0]  in_feat,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic                     in_done,
  input  logic [CLASS_W-1:0]       in_cls,
  input  logic [FSEL_W-1:0]        nd_fsel,
  input  logic [BIN_W-1:0]         nd_split,
  input  logic [ADDR_W-1:0]        nd_left,
  input  logic [ADDR_W-1:0]        nd_right,
  input  logic                     nd_leaf,
  input  logic [CLASS_W-1:0]       nd_class,
  output logic                     out_vld,
  output logic [N_FEAT*BIN_W-1:0]  out_feat,
  output logic [ADDR_W-1:0]        out_addr,
  output logic                     out_done,
  output logic [CLASS_W-1:0]       out_cls
);
  logic [BIN_W-1:0]   sel_bin;
  step_e              step;
  logic               step_ends;
  logic [ADDR_W-1:0]  nxt_addr;
  logic               nxt_done;
  logic [CLASS_W-1:0] nxt_cls;

  // Feature pick; an out-of-range select reads bin 0.
  always_comb begin
    sel_bin = '0;
    for (int f = 0; f < N_FEAT; f++)
      if (int'(nd_fsel) == f) sel_bin = in_feat[f*BIN_W +: BIN_W];
  end

  assign step      = pick_step(in_done, nd_leaf, DEEPEST, int'(sel_bin), int'(nd_split));
  assign step_ends = (step == STEP_LEAF);

  always_comb begin
    nxt_addr = in_addr;
    nxt_done = in_done;
    nxt_cls  = in_cls;
    unique case (step)
      STEP_PASS:  ;
      STEP_LEAF:  begin nxt_done = 1'b1; nxt_cls = nd_class; end
      STEP_LEFT:  nxt_addr = nd_left;
      STEP_RIGHT: nxt_addr = nd_right;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_feat <= '0;
      out_addr <= '0;
      out_done <= 1'b0;
      out_cls  <= '0;
    end else if (adv) begin
      out_vld  <= in_vld;
      out_feat <= in_feat;
      out_addr <= nxt_addr;
      out_done <= nxt_done;
      out_cls  <= nxt_cls;
    end
  end

  // R3: a label found upstream rides through unchanged.
  a_r3_label_carried: assert property (@(posedge clk) disable iff (!rst_n)
    adv && in_vld && in_done |=> out_done && out_cls == $past(in_cls));

  // R3: a leaf decision reaches the stage register.
  a_r3_leaf_latched: assert property (@(posedge clk) disable iff (!rst_n)
    adv && in_vld && step_ends |=> out_vld && out_done);

  // R6: a frozen stage keeps its contents.
  a_r6_stage_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_vld) && $stable(out_cls) && $stable(out_addr));

  generate
    if (DEEPEST) begin : g_deep
      // R3: the deepest level always finishes the walk.
      a_r3_deepest_ends: assert property (@(posedge clk) disable iff (!rst_n)
        adv && in_vld |=> out_done);
    end
  endgenerate

endmodule

// File: rtl/dtc_classifier.sv
module dtc_classifier
  import dtc_pkg::*;
#(
  parameter int N_FEAT  = 4,
  parameter int BIN_W   = 4,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 4,
  parameter int CLASS_W = 3,
  localparam int FEAT_W = N_FEAT * BIN_W,
  localparam int FSEL_W = idx_bits(N_FEAT),
  localparam int LVL_W  = idx_bits(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FEAT_W-1:0]  in_feat,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CLASS_W-1:0] out_class,
  input  logic               cfg_we,
  input  logic [LVL_W-1:0]   cfg_level,
  input  logic [ADDR_W-1:0]  cfg_node,
  input  logic [FSEL_W-1:0]  cfg_fsel,
  input  logic [BIN_W-1:0]   cfg_split,
  input  logic [ADDR_W-1:0]  cfg_left,
  input  logic [ADDR_W-1:0]  cfg_right,
  input  logic               cfg_leaf,
  input  logic [CLASS_W-1:0] cfg_class
);
  // Stage k carries the flow that level k is about to evaluate.
  logic               st_vld  [DEPTH+1];
  logic [FEAT_W-1:0]  st_feat [DEPTH+1];
  logic [ADDR_W-1:0]  st_addr [DEPTH+1];
  logic               st_done [DEPTH+1];
  logic [CLASS_W-1:0] st_cls  [DEPTH+1];

  logic               s0_vld;
  logic [FEAT_W-1:0]  s0_feat;
  logic               adv;
  logic               accept;
  logic               pipe_busy;
  logic               wr_go;

  assign adv      = !st_vld[DEPTH] || out_ready;
  assign in_ready = adv && !cfg_we;
  assign accept   = in_valid && in_ready;

  always_comb begin
    pipe_busy = 1'b0;
    for (int k = 0; k <= DEPTH; k++) pipe_busy |= st_vld[k];
  end

  assign wr_go = cfg_we && !pipe_busy;

  // Entry register: every walk starts at the root of level 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_vld  <= 1'b0;
      s0_feat <= '0;
    end else if (adv) begin
      s0_vld  <= accept;
      s0_feat <= in_feat;
    end
  end

  assign st_vld[0]  = s0_vld;
  assign st_feat[0] = s0_feat;
  assign st_addr[0] = '0;
  assign st_done[0] = 1'b0;
  assign st_cls[0]  = '0;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
      logic [FSEL_W-1:0]  nd_fsel;
      logic [BIN_W-1:0]   nd_split;
      logic [ADDR_W-1:0]  nd_left;
      logic [ADDR_W-1:0]  nd_right;
      logic               nd_leaf;
      logic [CLASS_W-1:0] nd_class;
      logic               lvl_we;

      assign lvl_we = wr_go && (cfg_level == LVL_W'(k));

      dtc_node_mem #(
        .ADDR_W(ADDR_W), .FSEL_W(FSEL_W), .BIN_W(BIN_W), .CLASS_W(CLASS_W)
      ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (pipe_busy),
        .wr_en    (lvl_we),
        .wr_addr  (cfg_node),
        .wr_fsel  (cfg_fsel),
        .wr_split (cfg_split),
        .wr_left  (cfg_left),
        .wr_right (cfg_right),
        .wr_leaf  (cfg_leaf),
        .wr_class (cfg_class),
        .rd_addr  (st_addr[k]),
        .rd_fsel  (nd_fsel),
        .rd_split (nd_split),
        .rd_left  (nd_left),
        .rd_right (nd_right),
        .rd_leaf  (nd_leaf),
        .rd_class (nd_class)
      );

      dtc_stage #(
        .N_FEAT(N_FEAT), .BIN_W(BIN_W), .FSEL_W(FSEL_W), .ADDR_W(ADDR_W),
        .CLASS_W(CLASS_W), .DEEPEST(k == DEPTH - 1)
      ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .in_vld   (st_vld[k]),
        .in_feat  (st_feat[k]),
        .in_addr  (st_addr[k]),
        .in_done  (st_done[k]),
        .in_cls   (st_cls[k]),
        .nd_fsel  (nd_fsel),
        .nd_split (nd_split),
        .nd_left  (nd_left),
        .nd_right (nd_right),
        .nd_leaf  (nd_leaf),
        .nd_class (nd_class),
        .out_vld  (st_vld[k+1]),
        .out_feat (st_feat[k+1]),
        .out_addr (st_addr[k+1]),
        .out_done (st_done[k+1]),
        .out_cls  (st_cls[k+1])
      );
    end
  endgenerate

  assign out_valid = st_vld[DEPTH];
  assign out_class = st_cls[DEPTH];

  // R6: a refused result is held steady.
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class));

  // R4: an accepted flow enters the first stage.
  a_r4_entry: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> st_vld[0]);

  // R7: configuration and flow entry never share a cycle.
  a_r7_cfg_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !in_ready);

  // R3: every result leaving the block has reached a leaf.
  a_r3_result_final: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> st_done[DEPTH]);

endmodule

// File: tb/dtc_classifier_test.sv
`timescale 1ns/1ps
module dtc_classifier_test;
  localparam int N_FEAT = 4, BIN_W = 4, DEPTH = 4, ADDR_W = 4, CLASS_W = 3;
  localparam int FEAT_W = N_FEAT * BIN_W;
  localparam int NVEC = 10;

  // Stimulus {feature bins f3 f2 f1 f0} and expected class for the bench tree:
  // f0>7 -> 5 ; f1>3 -> 2 ; f2<=9 -> 6 (deepest non-leaf) ; else 7.
  localparam logic [FEAT_W-1:0] VEC_FEAT [NVEC] = '{
    16'h0008, 16'h000F, 16'h0047, 16'h0937, 16'h0A00,
    16'hFF37, 16'h00F0, 16'h0023, 16'h0007, 16'h0A33 };
  localparam logic [CLASS_W-1:0] VEC_CLS [NVEC] = '{
    3'd5, 3'd5, 3'd2, 3'd6, 3'd7, 3'd7, 3'd2, 3'd6, 3'd6, 3'd7 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [FEAT_W-1:0] in_feat = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [CLASS_W-1:0] out_class;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_level = '0;
  logic [ADDR_W-1:0] cfg_node = '0;
  logic [1:0] cfg_fsel = '0;
  logic [BIN_W-1:0] cfg_split = '0;
  logic [ADDR_W-1:0] cfg_left = '0, cfg_right = '0;
  logic cfg_leaf = 1'b0;
  logic [CLASS_W-1:0] cfg_class = '0;

  int checks = 0, fails = 0, cyc = 0;
  bit bp_mode = 1'b0, finished = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [CLASS_W-1:0] exp_q [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  dtc_classifier #(.N_FEAT(N_FEAT), .BIN_W(BIN_W), .DEPTH(DEPTH),
                   .ADDR_W(ADDR_W), .CLASS_W(CLASS_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_feat(in_feat), .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .cfg_we(cfg_we), .cfg_level(cfg_level),
    .cfg_node(cfg_node), .cfg_fsel(cfg_fsel), .cfg_split(cfg_split),
    .cfg_left(cfg_left), .cfg_right(cfg_right), .cfg_leaf(cfg_leaf),
    .cfg_class(cfg_class));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Backpressure pattern on out_ready.
  always @(negedge clk) begin
    if (bp_mode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0];
    end else out_ready = 1'b1;
  end

  // Result collector: compares in order, watches stalls (R5, R6).
  initial begin
    bit prev_stall = 1'b0;
    logic [CLASS_W-1:0] prev_cls = '0;
    forever begin
      @(negedge clk); #3;
      if (rst_n) begin
        if (prev_stall)
          check(out_valid && out_class == prev_cls, "R6 held result",
                int'(out_class), int'(prev_cls));
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0)
            check(1'b0, "R5 unexpected result", int'(out_class), -1);
          else begin
            logic [CLASS_W-1:0] e;
            e = exp_q.pop_front();
            check(out_class == e, "R2/R3/R5 class in order", int'(out_class), int'(e));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_cls   = out_class;
      end
    end
  end

  task automatic send(input logic [FEAT_W-1:0] f, input logic [CLASS_W-1:0] e);
    @(negedge clk);
    in_valid = 1'b1;
    in_feat  = f;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(e);
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_node(input int lvl, input int idx, input int fs, input int sp,
                         input int l, input int r, input bit lf, input int c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_level = 2'(lvl); cfg_node = ADDR_W'(idx);
    cfg_fsel = 2'(fs); cfg_split = BIN_W'(sp); cfg_left = ADDR_W'(l);
    cfg_right = ADDR_W'(r); cfg_leaf = lf; cfg_class = CLASS_W'(c);
    #1;
    check(!in_ready, "R7 in_ready low during cfg write", int'(in_ready), 0);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready,   "R1 in_ready after reset",  int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty table classifies to class 0.
    send(16'h1234, 3'd0);
    stop_in();
    drain();

    // R8: load the tree while idle.
    wr_node(0, 0, 0, 7, 0, 1, 1'b0, 0);
    wr_node(1, 0, 1, 3, 0, 1, 1'b0, 0);
    wr_node(1, 1, 0, 0, 0, 0, 1'b1, 5);
    wr_node(2, 0, 2, 9, 0, 1, 1'b0, 0);
    wr_node(2, 1, 0, 0, 0, 0, 1'b1, 2);
    wr_node(3, 0, 3, 0, 0, 0, 1'b0, 6);
    wr_node(3, 1, 0, 0, 0, 0, 1'b1, 7);

    // R4: latency of a single flow.
    begin
      int t0;
      send(16'h0047, 3'd2);
      t0 = cyc + 1;
      stop_in();
      while (!out_valid) @(negedge clk);
      check(cyc - t0 == DEPTH, "R4 latency in edges", cyc - t0, DEPTH);
      drain();
    end

    // R2, R3, R5: vector table streamed back to back.
    for (int i = 0; i < NVEC; i++) begin
      int t_before;
      t_before = cyc;
      send(VEC_FEAT[i], VEC_CLS[i]);
      if (i > 0) check(cyc == t_before + 1, "R5 back-to-back accept", cyc - t_before, 1);
    end
    stop_in();
    drain();

    // R6: same vectors under random backpressure.
    bp_mode = 1'b1;
    for (int i = NVEC - 1; i >= 0; i--) send(VEC_FEAT[i], VEC_CLS[i]);
    stop_in();
    drain();
    bp_mode = 1'b0;
    drain();

    // R7: write while a flow is in flight is discarded.
    send(16'h0008, 3'd5);
    stop_in();
    wr_node(1, 1, 0, 0, 0, 0, 1'b1, 4);
    drain();
    send(16'h0008, 3'd5);
    stop_in();
    drain();

    // R8: the same write while idle takes effect.
    wr_node(1, 1, 0, 0, 0, 0, 1'b1, 4);
    send(16'h0008, 3'd4);
    send(16'h0003, 3'd6);
    stop_in();
    drain();
    check(exp_q.size() == 0, "R5 all results returned", exp_q.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule